// File: doc/BRIEF.md
# Burst Address Sequencer

This block drives the word address of a memory that serves four-beat bursts. A base address is captured when an address strobe is accepted. Every later advance moves the two least-significant address bits one beat further through a four-entry sequence. The upper address bits stay exactly as captured for the whole burst. The sequence is either a modulo-4 count upward from the captured offset or the captured offset XORed with a running beat number. After four beats it comes back to the captured offset.

Two strobes can start a burst. The controller strobe is always honoured. The processor strobe counts only while chip enable is low. When either strobe is accepted in a cycle, any advance request in that same cycle is dropped. While the advance input is inactive, the current address is held, so a burst can be paused and then resumed. The order-select input is expected to stay fixed while bursts are running. The output address comes straight from registered state through a small offset mapping, so it changes one clock edge after the input that caused the change.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the captured base and the beat count are cleared. After that edge `addr_out` is all zeros.
- R2: When `ctl_strobe_n` is low at a rising edge, the whole of `addr_in` is captured. From the next cycle `addr_out` equals that value, because the beat count restarts at 0.
- R3: A low `cpu_strobe_n` captures `addr_in` only if `chip_en_n` is also low at that edge. With `chip_en_n` high it has no effect, and `addr_out` keeps the value it had before.
- R4: With `order_sel` = 0 (linear), the low two bits of `addr_out` equal (captured low bits + beat count) mod 4.
- R5: With `order_sel` = 1 (interleaved), the low two bits of `addr_out` equal the captured low bits XOR the beat count.
- R6: The beat count runs 0,1,2,3 and then back to 0. After four advances the low bits are the captured offset again.
- R7: When no strobe is accepted and `step_n` is high at an edge, `addr_out` does not change.
- R8: Bits above bit 1 of `addr_out` equal the captured address bits for as long as no new strobe is accepted.
- R9: When a strobe is accepted in the same cycle that `step_n` is low, the load wins and the beat count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Word address offered with a strobe |
| ctl_strobe_n | input | 1 | Controller address strobe, active low, not gated |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low; gates the processor strobe |
| step_n | input | 1 | Advance the burst by one beat, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; static |
| addr_out | output | ADDR_W | Sequenced word address |

## Verification
The bench builds the block with `ADDR_W` = 8. This leaves six upper bits, enough to give each burst a distinct upper pattern, so a wrong upper bit or a stale capture shows up at once. In both orders the bench starts bursts from every one of the four low offsets. It pauses bursts partway and runs each of them through a full wrap. It also covers the cases where a strobe meets an advance in the same cycle, and where the processor strobe arrives while chip enable is inactive.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_ctl_t;

    function automatic ofs_t map_offset(ofs_t start, ofs_t beat, order_e ord);
        ofs_t res;
        if (ord == ORD_XOR) begin
            res = start ^ beat;
        end else begin
            res = start + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/burst_load_dec.sv
module burst_load_dec
    import burst_seq_pkg::*;
(
    input  logic     ctl_strobe_n,
    input  logic     cpu_strobe_n,
    input  logic     chip_en_n,
    input  logic     step_n,
    output seq_ctl_t ctl
);
    logic cpu_take;

    always_comb begin
        cpu_take = ~cpu_strobe_n & ~chip_en_n;
        ctl.load = ~ctl_strobe_n | cpu_take;
        ctl.step = ~step_n & ~ctl.load;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output ofs_t              beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (ctl.load) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (ctl.step) begin
            beat_q <= beat_q + ofs_t'(1);
        end
    end
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
    import burst_seq_pkg::*;
(
    input  ofs_t start_ofs,
    input  ofs_t beat,
    input  logic order_sel,
    output ofs_t cur_ofs
);
    order_e ord;

    always_comb begin
        ord     = order_e'(order_sel);
        cur_ofs = map_offset(start_ofs, beat, ord);
    end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctl_strobe_n,
    input  logic              cpu_strobe_n,
    input  logic              chip_en_n,
    input  logic              step_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - OFS_W;

    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] base_q;
    ofs_t              beat_q;
    ofs_t              cur_ofs;

    burst_load_dec u_dec (
        .ctl_strobe_n (ctl_strobe_n),
        .cpu_strobe_n (cpu_strobe_n),
        .chip_en_n    (chip_en_n),
        .step_n       (step_n),
        .ctl          (ctl)
    );

    burst_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_ofs_map u_map (
        .start_ofs (base_q[OFS_W-1:0]),
        .beat      (beat_q),
        .order_sel (order_sel),
        .cur_ofs   (cur_ofs)
    );

    generate
        if (HI_W > 0) begin : g_upper
            assign addr_out = {base_q[ADDR_W-1:OFS_W], cur_ofs};
        end else begin : g_low_only
            assign addr_out = cur_ofs[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ctl_strobe_n,
    input logic              cpu_strobe_n,
    input logic              chip_en_n,
    input logic              step_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out
);
    logic accept;
    assign accept = ~ctl_strobe_n | (~cpu_strobe_n & ~chip_en_n);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> addr_out == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> addr_out == $past(addr_in));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && step_n) ##1 $stable(order_sel) |-> $stable(addr_out));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && !step_n && !order_sel) ##1 !order_sel |->
        addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));

    // R3
    gated_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe_n && !cpu_strobe_n && chip_en_n && step_n) ##1 $stable(order_sel)
        |-> $stable(addr_out));
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_seq_top_tb.sv
module burst_seq_top_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          ctl_strobe_n = 1'b1;
    logic          cpu_strobe_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          step_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int failures = 0;
    int ref_base = 0;
    int ref_beat = 0;

    burst_seq_top #(.ADDR_W(AW)) u_dut (
        .clk (clk), .rst (rst), .addr_in (addr_in),
        .ctl_strobe_n (ctl_strobe_n), .cpu_strobe_n (cpu_strobe_n),
        .chip_en_n (chip_en_n), .step_n (step_n), .order_sel (order_sel),
        .addr_out (addr_out)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] expect_addr();
        int lo;
        int ofs;
        lo = ref_base % 4;
        ofs = order_sel ? (lo ^ ref_beat) : ((lo + ref_beat) % 4);
        return AW'((ref_base / 4) * 4 + ofs);
    endfunction

    task automatic check(input string tag);
        logic [AW-1:0] exp;
        exp = expect_addr();
        checks++;
        if (addr_out !== exp) begin
            failures++;
            $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, exp);
        end
    endtask

    task automatic cyc(input logic cs_n, input logic ps_n, input logic ce_n,
                       input logic st_n, input logic [AW-1:0] a, input string tag);
        ctl_strobe_n = cs_n;
        cpu_strobe_n = ps_n;
        chip_en_n    = ce_n;
        step_n       = st_n;
        addr_in      = a;
        @(posedge clk);
        if (!cs_n || (!ps_n && !ce_n)) begin
            ref_base = int'(a);
            ref_beat = 0;
        end else if (!st_n) begin
            ref_beat = (ref_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag);
        ctl_strobe_n = 1'b1;
        cpu_strobe_n = 1'b1;
        step_n       = 1'b1;
    endtask

    task automatic burst(input logic [AW-1:0] a, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a, "R2 load");
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, tag);
        end
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset");
        rst = 1'b0;

        order_sel = 1'b0;
        burst(8'h54, "R4 R6 linear from 00");
        burst(8'h5d, "R4 R6 linear from 01");
        burst(8'ha2, "R4 R6 R8 linear from 10");
        burst(8'h3b, "R4 R6 R8 linear from 11");

        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hc6, "R2 load");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 step");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hff, "R7 hold");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'h11, "R7 hold");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 resume");

        order_sel = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h40, "R2 load");
        burst(8'h71, "R5 R6 interleaved from 01");
        burst(8'h8a, "R5 R6 interleaved from 10");
        burst(8'he7, "R5 R6 R8 interleaved from 11");
        burst(8'h0c, "R5 R6 interleaved from 00");

        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h93, "R3 cpu load enabled");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 step");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h2e, "R3 cpu strobe ignored");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h2e, "R3 ignored strobe with step");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hb5, "R9 load beats step");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R9 step after load");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h6b, "R9 cpu load beats step");

        order_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R2 load");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 step");
        rst = 1'b1;
        ref_base = 0;
        ref_beat = 0;
        @(negedge clk);
        check("R1 reset mid burst");
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule